// File: doc/BRIEF.md
# Pin Boundary Scan Data Register

This block is the data-register part of a boundary scan path that sits between a chip's core logic and its pads. Each pin position adds a slice of scan cells: a bidirectional pin adds three cells, and an input-only pin adds one. A parameter bit per pin selects the slice kind, and the total chain length follows from that pin mix. A test access controller drives the capture, shift and update strobes. Serial data enters at the first cell of pin 0 and leaves from the last cell of the highest pin.

Each cell has two stages. The first is a shift/capture flop that advances on the rising test clock. The second, present on the output and enable cells, is an update stage that loads on the falling clock edge. The pads therefore never see bits rippling through the chain. When the external-test select is high, the update stage drives each bidirectional pad's data and active-low enable. When it is low, the pads follow the core exactly.

Top module: `pin_scan_chain`

## Requirements
- R1: The chain holds exactly the sum over pins of 3 cells for each bidirectional pin and 1 cell for each input-only pin. A word shifted fully in comes back out unchanged on the next full transfer.
- R2: Counting from the scan input, pin 0's slice comes first. Inside a bidirectional slice the order is pad input, then core output data, then active-low enable. An input-only slice holds only the pad input cell.
- R3: While `shift_en` is high, every rising edge of `tck` moves each cell to the next cell toward `scan_out`. `scan_in` enters cell 0, and `scan_out` always shows the last cell. If `shift_en` and `capture_en` are both high, the shift takes priority.
- R4: On a rising edge with `capture_en` high and `shift_en` low, each input cell loads `pad_in`, each data cell loads `core_out`, and each enable cell loads `core_oe_n`.
- R5: The update stage of each bidirectional pin loads its data and enable cells on a falling edge of `tck` while `update_en` is high. At all other times it holds, so shifting never changes the pads.
- R6: While `extest` is high, each bidirectional pin's `pad_out` and `pad_oe_n` equal its update stage.
- R7: While `extest` is low, each bidirectional pin's `pad_out` equals `core_out` and its `pad_oe_n` equals `core_oe_n`, whatever the chain holds.
- R8: `pad_oe_n` is active low: a 1 means the pad is high impedance. Input-only pins always give `pad_oe_n` = 1 and `pad_out` = 0.
- R9: `core_in` always equals `pad_in`.
- R10: While `rst_n` is low, all chain cells clear to 0. The update stage also resets: data to 0 and enable to 1, so the pad is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from the last cell |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Update-stage load strobe (falling edge) |
| extest | input | 1 | Pads driven from update stage |
| core_out | input | NUM_PINS | Core output data per pin |
| core_oe_n | input | NUM_PINS | Core active-low output enable per pin |
| core_in | output | NUM_PINS | Pad input data returned to core |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Data driven to each pad |
| pad_oe_n | output | NUM_PINS | Active-low pad driver enable |

## Verification
On every rising clock edge, the checker confirms four things. A shift moves the whole chain by one cell and brings in `scan_in`. A capture without a shift loads the parallel vector. The update stage holds whenever its strobe is low. The pad muxes follow either the core or the update stage, according to `extest`. The slice layout and its order from the scan input can only be shown by the bench, as can the end-to-end chain length and the way captured pin values come out serially. The bench does this by capturing random pin values, reading them back bit by bit, then loading random patterns and seeing them arrive at the pads.

// File: rtl/pin_scan_pkg.sv
package pin_scan_pkg;
  // number of scan cells a pin slice contributes
  function automatic int cells_of(input logic bidir);
    return bidir ? 3 : 1;
  endfunction

  // first cell index of a pin's slice, counted from scan input
  function automatic int cell_base(input logic [31:0] kinds, input int pin);
    int acc;
    acc = 0;
    for (int i = 0; i < pin; i++) acc += cells_of(kinds[i]);
    return acc;
  endfunction

  function automatic int chain_len(input logic [31:0] kinds, input int n);
    return cell_base(kinds, n);
  endfunction
endpackage

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
  parameter int LEN = 4
) (
  input  logic           tck,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           capture_en,
  input  logic           scan_in,
  input  logic [LEN-1:0] par_in,
  output logic [LEN-1:0] chain_q,
  output logic           scan_out
);
  logic [LEN-1:0] next_d;

  always_comb begin
    next_d = chain_q;
    if (shift_en)        next_d = {chain_q[LEN-2:0], scan_in};
    else if (capture_en) next_d = par_in;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= next_d;
  end

  assign scan_out = chain_q[LEN-1];
endmodule

// File: rtl/scan_update_reg.sv
module scan_update_reg #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         update_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)         q <= RST_VAL;
    else if (update_en) q <= d;
  end
endmodule

// File: rtl/pin_drive_mux.sv
module pin_drive_mux (
  input  logic extest,
  input  logic core_out,
  input  logic core_oe_n,
  input  logic upd_out,
  input  logic upd_oe_n,
  output logic pad_out,
  output logic pad_oe_n
);
  assign pad_out  = extest ? upd_out  : core_out;
  assign pad_oe_n = extest ? upd_oe_n : core_oe_n;
endmodule

// File: rtl/pin_scan_chain.sv
module pin_scan_chain
  import pin_scan_pkg::*;
#(
  parameter int                  NUM_PINS  = 4,
  parameter logic [NUM_PINS-1:0] PIN_BIDIR = 4'b1101
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic                capture_en,
  input  logic                shift_en,
  input  logic                update_en,
  input  logic                extest,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe_n,
  output logic [NUM_PINS-1:0] core_in,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe_n
);
  localparam logic [31:0] KINDS     = 32'(PIN_BIDIR);
  localparam int          CHAIN_LEN = chain_len(KINDS, NUM_PINS);

  // named internal events, visible to the bound checker
  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [NUM_PINS-1:0]  upd_out_q;
  logic [NUM_PINS-1:0]  upd_oe_q;

  scan_shift_reg #(.LEN(CHAIN_LEN)) u_shift (
    .tck(tck), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
    .scan_in(scan_in), .par_in(cap_vec), .chain_q(chain_q), .scan_out(scan_out)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BASE = cell_base(KINDS, p);
    if (PIN_BIDIR[p]) begin : g_bidir
      logic [1:0] upd_q;
      assign cap_vec[BASE]   = pad_in[p];
      assign cap_vec[BASE+1] = core_out[p];
      assign cap_vec[BASE+2] = core_oe_n[p];

      scan_update_reg #(.W(2), .RST_VAL(2'b10)) u_upd (
        .tck(tck), .rst_n(rst_n), .update_en(update_en),
        .d({chain_q[BASE+2], chain_q[BASE+1]}), .q(upd_q)
      );
      assign upd_out_q[p] = upd_q[0];
      assign upd_oe_q[p]  = upd_q[1];

      pin_drive_mux u_mux (
        .extest(extest), .core_out(core_out[p]), .core_oe_n(core_oe_n[p]),
        .upd_out(upd_q[0]), .upd_oe_n(upd_q[1]),
        .pad_out(pad_out[p]), .pad_oe_n(pad_oe_n[p])
      );
    end else begin : g_in_only
      logic unused_core_bits;
      assign unused_core_bits = core_out[p] ^ core_oe_n[p];
      assign cap_vec[BASE] = pad_in[p];
      assign upd_out_q[p]  = 1'b0;
      assign upd_oe_q[p]   = 1'b1;
      assign pad_out[p]    = 1'b0;
      assign pad_oe_n[p]   = 1'b1;
    end
  end

  assign core_in = pad_in;
endmodule

// File: rtl/pin_scan_chain_chk.sv
module pin_scan_chain_chk #(
  parameter int                  NUM_PINS  = 4,
  parameter logic [NUM_PINS-1:0] PIN_BIDIR = 4'b1101,
  parameter int                  CHAIN_LEN = 10
) (
  input logic                 tck,
  input logic                 rst_n,
  input logic                 scan_in,
  input logic                 shift_en,
  input logic                 capture_en,
  input logic                 update_en,
  input logic                 extest,
  input logic [NUM_PINS-1:0]  core_out,
  input logic [NUM_PINS-1:0]  core_oe_n,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_PINS-1:0]  pad_oe_n,
  input logic [CHAIN_LEN-1:0] cap_vec,
  input logic [CHAIN_LEN-1:0] chain_q,
  input logic [NUM_PINS-1:0]  upd_out_q,
  input logic [NUM_PINS-1:0]  upd_oe_q
);
  a_r3_shift_moves: assert property (@(posedge tck) disable iff (!rst_n)
    shift_en |=> chain_q == {$past(chain_q[CHAIN_LEN-2:0]), $past(scan_in)});

  a_r4_capture_loads: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && !shift_en) |=> chain_q == $past(cap_vec));

  a_r5_update_holds: assert property (@(posedge tck) disable iff (!rst_n)
    !update_en |-> ($stable(upd_out_q) && $stable(upd_oe_q)));

  a_r6_extest_drive: assert property (@(posedge tck) disable iff (!rst_n)
    extest |-> ((((pad_out ^ upd_out_q) | (pad_oe_n ^ upd_oe_q)) & PIN_BIDIR) == '0));

  a_r7_transparent: assert property (@(posedge tck) disable iff (!rst_n)
    !extest |-> ((((pad_out ^ core_out) | (pad_oe_n ^ core_oe_n)) & PIN_BIDIR) == '0));

  a_r10_reset_clear: assert property (@(posedge tck)
    !rst_n |-> (chain_q == '0));
endmodule

bind pin_scan_chain pin_scan_chain_chk #(
  .NUM_PINS(NUM_PINS), .PIN_BIDIR(PIN_BIDIR), .CHAIN_LEN(CHAIN_LEN)
) u_chk (
  .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
  .capture_en(capture_en), .update_en(update_en), .extest(extest),
  .core_out(core_out), .core_oe_n(core_oe_n), .pad_out(pad_out),
  .pad_oe_n(pad_oe_n), .cap_vec(cap_vec), .chain_q(chain_q),
  .upd_out_q(upd_out_q), .upd_oe_q(upd_oe_q)
);

// File: tb/pin_scan_chain_tb.sv
module pin_scan_chain_tb_top;
  localparam int              NP    = 4;
  localparam logic [NP-1:0]   BIDIR = 4'b1101;

  function automatic int bench_len();
    int n;
    n = 0;
    for (int p = 0; p < NP; p++) n += BIDIR[p] ? 3 : 1;
    return n;
  endfunction
  localparam int LEN = bench_len();

  logic tck = 1'b0;
  logic rst_n, scan_in, scan_out, capture_en, shift_en, update_en, extest;
  logic [NP-1:0] core_out, core_oe_n, core_in, pad_in, pad_out, pad_oe_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 tck = ~tck;   // 125 MHz

  pin_scan_chain #(.NUM_PINS(NP), .PIN_BIDIR(BIDIR)) dut_i (
    .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .extest(extest), .core_out(core_out), .core_oe_n(core_oe_n),
    .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe_n(pad_oe_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge tck) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  // captured chain image: per pin, input then data then enable
  function automatic logic [LEN-1:0] exp_cap(input logic [NP-1:0] pi,
      input logic [NP-1:0] co, input logic [NP-1:0] coe);
    logic [LEN-1:0] v;
    int pos;
    v = '0; pos = 0;
    for (int p = 0; p < NP; p++) begin
      v[pos] = pi[p]; pos++;
      if (BIDIR[p]) begin v[pos] = co[p]; v[pos+1] = coe[p]; pos += 2; end
    end
    return v;
  endfunction

  // update-stage values a pattern produces (input-only: 0 data, 1 enable)
  function automatic logic [2*NP-1:0] exp_upd(input logic [LEN-1:0] pat);
    logic [NP-1:0] o, e;
    int pos;
    pos = 0; o = '0; e = '1;
    for (int p = 0; p < NP; p++) begin
      if (BIDIR[p]) begin o[p] = pat[pos+1]; e[p] = pat[pos+2]; pos += 3; end
      else pos++;
    end
    return {e, o};
  endfunction

  logic [NP-1:0] lat_o, lat_e;

  function automatic logic [2*NP-1:0] exp_pads(input logic ext);
    logic [NP-1:0] o, e;
    for (int p = 0; p < NP; p++) begin
      if (!BIDIR[p])  begin o[p] = 1'b0;        e[p] = 1'b1; end
      else if (ext)   begin o[p] = lat_o[p];    e[p] = lat_e[p]; end
      else            begin o[p] = core_out[p]; e[p] = core_oe_n[p]; end
    end
    return {e, o};
  endfunction

  task automatic tick();
    @(posedge tck); #2;
  endtask

  task automatic xfer(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    shift_en = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      dout[LEN-1-i] = scan_out;
      scan_in = din[LEN-1-i];
      tick();
    end
    shift_en = 1'b0;
  endtask

  task automatic capture();
    capture_en = 1'b1; tick(); capture_en = 1'b0;
  endtask

  task automatic update(input logic [LEN-1:0] pat);
    logic [2*NP-1:0] u;
    update_en = 1'b1; tick(); update_en = 1'b0;
    u = exp_upd(pat);
    lat_o = u[NP-1:0]; lat_e = u[2*NP-1:NP];
  endtask

  initial begin
    logic [LEN-1:0] got, pat;
    void'($urandom(32'd2024));
    rst_n = 1'b0; scan_in = 0; capture_en = 0; shift_en = 0; update_en = 0;
    extest = 1'b1; core_out = '0; core_oe_n = '0; pad_in = '0;
    lat_o = '0; lat_e = '1;
    repeat (3) @(posedge tck);
    #2;
    // R10: reset state
    chk("R10 scan_out", 64'(scan_out), 64'd0);
    chk("R10 pad_oe_n", 64'(pad_oe_n), 64'({NP{1'b1}}));
    chk("R10 pad_out", 64'(pad_out), 64'd0);
    rst_n = 1'b1; extest = 1'b0;
    tick();

    // R1/R2: full transfer round-trip and exact length
    pat = LEN'(10'b1011001110);
    xfer(pat, got);
    chk("R1 reset chain readout", 64'(got), 64'd0);
    xfer('0, got);
    chk("R1 round trip", 64'(got), 64'(pat));

    // R2: slice order via single capture pattern (pin1 input-only)
    pad_in = 4'b0010; core_out = 4'b0001; core_oe_n = 4'b1000;
    capture(); xfer('0, got);
    chk("R2 slice layout", 64'(got), 64'(exp_cap(pad_in, core_out, core_oe_n)));
    chk("R2 pin1 input cell at 3", 64'(got[3]), 64'd1);

    // R3: shift wins over capture
    xfer('1, got);
    pad_in = '1; core_out = '1; core_oe_n = '1;
    scan_in = 1'b0; shift_en = 1'b1; capture_en = 1'b1; tick();
    shift_en = 1'b0; capture_en = 1'b0;
    xfer('0, got);
    chk("R3 shift priority", 64'(got), 64'({{(LEN-1){1'b1}}, 1'b0}));

    // R8: enable=1 pattern in extest gives high impedance
    pat = '1; xfer(pat, got); update(pat); extest = 1'b1; #1;
    chk("R8 oe_n high-Z", 64'(pad_oe_n), 64'({NP{1'b1}}));
    chk("R8 input-only pad_out", 64'(pad_out[1]), 64'd0);
    extest = 1'b0;

    // randomized scenarios
    for (int it = 0; it < 30; it++) begin
      pad_in = NP'($urandom); core_out = NP'($urandom); core_oe_n = NP'($urandom);
      extest = $urandom_range(0, 1);
      pat = LEN'($urandom);
      #1;
      chk("R9 core_in", 64'(core_in), 64'(pad_in));
      capture();
      xfer(pat, got);
      chk("R4 capture readout", 64'(got), 64'(exp_cap(pad_in, core_out, core_oe_n)));
      chk("R5 pads hold during shift", 64'({pad_oe_n, pad_out}), 64'(exp_pads(extest)));
      update(pat);
      chk(extest ? "R6 extest pads" : "R7 transparent pads",
          64'({pad_oe_n, pad_out}), 64'(exp_pads(extest)));
      extest = ~extest; #1;
      chk(extest ? "R6 extest toggle" : "R7 toggle",
          64'({pad_oe_n, pad_out}), 64'(exp_pads(extest)));
    end
    finish_run();
  end
endmodule